// File: doc/BRIEF.md
# Compare-and-Branch Next-PC Unit

This block resolves the control-flow outcome of one jump-class instruction per cycle. The execute stage hands it the current program counter, the width mode (full 64-bit or narrow 32-bit), the 4-bit operation code, an operand-select bit, the destination and source register values, the sign-extended immediate and the 16-bit branch offset. One clock later the block returns whether the branch was taken, the program counter to fetch next, and flags that mark a subroutine call, a program exit or an illegal encoding.

Instructions occupy 8-byte slots. A taken branch moves the PC by the signed offset plus one slot, so an offset of -1 branches to the instruction itself. Anything that does not redirect advances by one slot. Calls are only flagged, with their 32-bit target taken from the low half of the immediate. Dispatching the call is left to the surrounding pipeline. Exit and illegal encodings both leave the PC where it is, so the pipeline can halt or trap on it.

Top module: `branch_next_pc`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, out_valid, all four flags, next_pc and call_target read zero.
- R2: out_valid is in_valid delayed by one clock. When out_valid is low, taken, call, halt and illegal are all zero and call_target is zero.
- R3: A taken branch gives next_pc = pc + (sign-extended offset + 1) * 8. Code 0x0 in wide mode is always taken, and offset -1 yields pc itself.
- R4: A not-taken comparison and a call both give next_pc = pc + 8 with taken low.
- R5: Code 0x1 is taken when the operands are equal, 0x5 when they differ, and 0x4 when the bitwise AND of the operands is nonzero.
- R6: Unsigned compares are 0x2 (greater), 0x3 (greater or equal), 0xA (less) and 0xB (less or equal).
- R7: Signed two's-complement compares are 0x6 (greater), 0x7 (greater or equal), 0xC (less) and 0xD (less or equal).
- R8: With narrow=1 every compare uses only bits 31:0 of both operands. The signed codes treat bit 31 as the sign.
- R9: use_reg=0 selects the immediate as the second operand. use_reg=1 selects the source register.
- R10: Code 0x8 in wide mode raises call for one result and puts immediate bits 31:0 on call_target. taken stays low.
- R11: Code 0x9 in wide mode raises halt, keeps taken low, and returns next_pc equal to the incoming pc.
- R12: Codes 0xE and 0xF in either mode, and codes 0x0, 0x8 and 0x9 with narrow=1, raise illegal with taken, call and halt low and next_pc equal to the incoming pc.
- R13: At most one of taken, call, halt and illegal is high on any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| pc_i | input | PC_W | Program counter of the instruction |
| narrow_i | input | 1 | 1 = compare low 32 bits only |
| code_i | input | 4 | Jump operation code |
| use_reg_i | input | 1 | 1 = second operand is src_i, 0 = imm_i |
| dst_i | input | DATA_W | Destination register value (first operand) |
| src_i | input | DATA_W | Source register value |
| imm_i | input | DATA_W | Sign-extended immediate |
| off_i | input | OFF_W | Signed branch offset in slots |
| out_valid | output | 1 | Result present |
| taken_o | output | 1 | Branch redirects the PC |
| next_pc_o | output | PC_W | Next program counter |
| call_o | output | 1 | Instruction is a call |
| call_target_o | output | TGT_W | Call target field |
| halt_o | output | 1 | Program exit |
| illegal_o | output | 1 | Encoding not allowed |

## Verification
The bench targets operands that tell apart the different compare readings. An all-ones value against one is greater when unsigned but less when signed, so a design that mixes up the two comparators fails there. Values that agree in the low word but differ above bit 31 catch a narrow mode that still looks at the upper half. A low word of 0x80000000 catches a narrow signed compare that takes its sign from bit 63. Offsets of -1 and -3 catch a target adder that drops the extra slot or zero-extends the offset. Each narrow-only illegal code is sent on its own, so a decoder that lets narrow always, call or exit through shows up as a wrong flag or a moved PC.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;

    typedef enum logic [3:0] {
        JC_ALWAYS = 4'h0,
        JC_EQ     = 4'h1,
        JC_UGT    = 4'h2,
        JC_UGE    = 4'h3,
        JC_BITS   = 4'h4,
        JC_NE     = 4'h5,
        JC_SGT    = 4'h6,
        JC_SGE    = 4'h7,
        JC_CALL   = 4'h8,
        JC_EXIT   = 4'h9,
        JC_ULT    = 4'hA,
        JC_ULE    = 4'hB,
        JC_SLT    = 4'hC,
        JC_SLE    = 4'hD,
        JC_RSV_E  = 4'hE,
        JC_RSV_F  = 4'hF
    } jcode_e;

    typedef struct packed {
        logic taken;
        logic call;
        logic halt;
        logic illegal;
    } flags_t;

endpackage

// File: rtl/bnpc_operand_sel.sv
module bnpc_operand_sel #(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] imm_i,
    input  logic              use_reg_i,
    input  logic              narrow_i,
    output logic [DATA_W-1:0] lhs_o,
    output logic [DATA_W-1:0] rhs_o,
    output logic              lhs_neg_o,
    output logic              rhs_neg_o
);
    localparam int HI_W = DATA_W - NARROW_W;

    logic [DATA_W-1:0] rhs_raw;
    assign rhs_raw = use_reg_i ? src_i : imm_i;

    generate
        if (HI_W > 0) begin : g_narrow
            // Narrow mode zero-extends the low word; the sign bit is
            // taken from the top of the narrow field instead.
            always_comb begin
                if (narrow_i) begin
                    lhs_o     = {{HI_W{1'b0}}, dst_i[NARROW_W-1:0]};
                    rhs_o     = {{HI_W{1'b0}}, rhs_raw[NARROW_W-1:0]};
                    lhs_neg_o = dst_i[NARROW_W-1];
                    rhs_neg_o = rhs_raw[NARROW_W-1];
                end else begin
                    lhs_o     = dst_i;
                    rhs_o     = rhs_raw;
                    lhs_neg_o = dst_i[DATA_W-1];
                    rhs_neg_o = rhs_raw[DATA_W-1];
                end
            end
        end else begin : g_flat
            assign lhs_o     = dst_i;
            assign rhs_o     = rhs_raw;
            assign lhs_neg_o = dst_i[DATA_W-1];
            assign rhs_neg_o = rhs_raw[DATA_W-1];
        end
    endgenerate

endmodule

// File: rtl/bnpc_cond_eval.sv
module bnpc_cond_eval
    import bnpc_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] lhs_i,
    input  logic [DATA_W-1:0] rhs_i,
    input  logic              lhs_neg_i,
    input  logic              rhs_neg_i,
    input  jcode_e            code_i,
    output logic              hit_o
);
    logic is_eq;
    logic is_ult;
    logic is_slt;
    logic any_bits;

    assign is_eq    = (lhs_i == rhs_i);
    assign is_ult   = (lhs_i < rhs_i);
    // One magnitude comparator serves both readings: differing signs
    // decide the signed order directly, equal signs defer to magnitude.
    assign is_slt   = (lhs_neg_i != rhs_neg_i) ? lhs_neg_i : is_ult;
    assign any_bits = |(lhs_i & rhs_i);

    always_comb begin
        case (code_i)
            JC_ALWAYS: hit_o = 1'b1;
            JC_EQ:     hit_o = is_eq;
            JC_NE:     hit_o = !is_eq;
            JC_BITS:   hit_o = any_bits;
            JC_UGT:    hit_o = !is_ult && !is_eq;
            JC_UGE:    hit_o = !is_ult;
            JC_ULT:    hit_o = is_ult;
            JC_ULE:    hit_o = is_ult || is_eq;
            JC_SGT:    hit_o = !is_slt && !is_eq;
            JC_SGE:    hit_o = !is_slt;
            JC_SLT:    hit_o = is_slt;
            JC_SLE:    hit_o = is_slt || is_eq;
            default:   hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bnpc_target.sv
module bnpc_target #(
    parameter int PC_W       = 64,
    parameter int OFF_W      = 16,
    parameter int SLOT_BYTES = 8
) (
    input  logic [PC_W-1:0]  pc_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [PC_W-1:0]  seq_pc_o,
    output logic [PC_W-1:0]  jump_pc_o
);
    localparam int SLOT_SH = $clog2(SLOT_BYTES);

    logic [PC_W-1:0] off_ext;
    logic [PC_W-1:0] slots;

    assign off_ext   = {{(PC_W-OFF_W){off_i[OFF_W-1]}}, off_i};
    assign slots     = off_ext + PC_W'(1);
    assign jump_pc_o = pc_i + (slots << SLOT_SH);
    assign seq_pc_o  = pc_i + PC_W'(SLOT_BYTES);

endmodule

// File: rtl/branch_next_pc.sv
module branch_next_pc
    import bnpc_pkg::*;
#(
    parameter int PC_W       = 64,
    parameter int DATA_W     = 64,
    parameter int NARROW_W   = 32,
    parameter int OFF_W      = 16,
    parameter int TGT_W      = 32,
    parameter int SLOT_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PC_W-1:0]   pc_i,
    input  logic              narrow_i,
    input  logic [3:0]        code_i,
    input  logic              use_reg_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [DATA_W-1:0] imm_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic              out_valid,
    output logic              taken_o,
    output logic [PC_W-1:0]   next_pc_o,
    output logic              call_o,
    output logic [TGT_W-1:0]  call_target_o,
    output logic              halt_o,
    output logic              illegal_o
);
    typedef struct packed {
        logic             valid;
        flags_t           flags;
        logic [PC_W-1:0]  npc;
        logic [TGT_W-1:0] tgt;
    } state_t;

    state_t state_d, state_q;

    jcode_e            code;
    logic [DATA_W-1:0] lhs, rhs;
    logic              lhs_neg, rhs_neg;
    logic              cond_hit;
    logic [PC_W-1:0]   seq_pc, jump_pc;

    assign code = jcode_e'(code_i);

    bnpc_operand_sel #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) u_opsel (
        .dst_i     (dst_i),
        .src_i     (src_i),
        .imm_i     (imm_i),
        .use_reg_i (use_reg_i),
        .narrow_i  (narrow_i),
        .lhs_o     (lhs),
        .rhs_o     (rhs),
        .lhs_neg_o (lhs_neg),
        .rhs_neg_o (rhs_neg)
    );

    bnpc_cond_eval #(
        .DATA_W (DATA_W)
    ) u_cond (
        .lhs_i     (lhs),
        .rhs_i     (rhs),
        .lhs_neg_i (lhs_neg),
        .rhs_neg_i (rhs_neg),
        .code_i    (code),
        .hit_o     (cond_hit)
    );

    bnpc_target #(
        .PC_W       (PC_W),
        .OFF_W      (OFF_W),
        .SLOT_BYTES (SLOT_BYTES)
    ) u_tgt (
        .pc_i      (pc_i),
        .off_i     (off_i),
        .seq_pc_o  (seq_pc),
        .jump_pc_o (jump_pc)
    );

    always_comb begin
        state_d = '0;
        if (in_valid) begin
            state_d.valid = 1'b1;
            state_d.npc   = seq_pc;
            case (code)
                JC_RSV_E, JC_RSV_F: begin
                    state_d.flags.illegal = 1'b1;
                end
                JC_CALL: begin
                    if (narrow_i) begin
                        state_d.flags.illegal = 1'b1;
                    end else begin
                        state_d.flags.call = 1'b1;
                        state_d.tgt        = imm_i[TGT_W-1:0];
                    end
                end
                JC_EXIT: begin
                    if (narrow_i) state_d.flags.illegal = 1'b1;
                    else          state_d.flags.halt    = 1'b1;
                end
                JC_ALWAYS: begin
                    if (narrow_i) state_d.flags.illegal = 1'b1;
                    else          state_d.flags.taken   = 1'b1;
                end
                default: begin
                    state_d.flags.taken = cond_hit;
                end
            endcase
            if (state_d.flags.taken) begin
                state_d.npc = jump_pc;
            end else if (state_d.flags.halt || state_d.flags.illegal) begin
                state_d.npc = pc_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid     = state_q.valid;
    assign taken_o       = state_q.flags.taken;
    assign call_o        = state_q.flags.call;
    assign halt_o        = state_q.flags.halt;
    assign illegal_o     = state_q.flags.illegal;
    assign next_pc_o     = state_q.npc;
    assign call_target_o = state_q.tgt;

endmodule

module bnpc_chk #(
    parameter int PC_W       = 64,
    parameter int TGT_W      = 32,
    parameter int SLOT_BYTES = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [PC_W-1:0]  pc_i,
    input logic [3:0]       code_i,
    input logic [TGT_W-1:0] imm_lo,
    input logic             out_valid,
    input logic             taken_o,
    input logic [PC_W-1:0]  next_pc_o,
    input logic             call_o,
    input logic [TGT_W-1:0] call_target_o,
    input logic             halt_o,
    input logic             illegal_o
);
    // R13
    flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({taken_o, call_o, halt_o, illegal_o}));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!(taken_o || call_o || halt_o || illegal_o) && call_target_o == '0));

    // R11
    exit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && halt_o) |-> next_pc_o == $past(pc_i));

    // R12
    illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && illegal_o) |-> next_pc_o == $past(pc_i));

    // R12
    rsv_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && code_i >= 4'hE) |=> illegal_o);

    // R10
    call_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && call_o) |-> call_target_o == $past(imm_lo));

    // R4
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !taken_o && !halt_o && !illegal_o) |->
            next_pc_o == $past(pc_i) + PC_W'(SLOT_BYTES));

endmodule

bind branch_next_pc bnpc_chk #(
    .PC_W       (PC_W),
    .TGT_W      (TGT_W),
    .SLOT_BYTES (SLOT_BYTES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .pc_i          (pc_i),
    .code_i        (code_i),
    .imm_lo        (imm_i[TGT_W-1:0]),
    .out_valid     (out_valid),
    .taken_o       (taken_o),
    .next_pc_o     (next_pc_o),
    .call_o        (call_o),
    .call_target_o (call_target_o),
    .halt_o        (halt_o),
    .illegal_o     (illegal_o)
);

// File: tb/branch_next_pc_bench.sv
`timescale 1ns/1ps
module branch_next_pc_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] pc_i = '0;
    logic        narrow_i = 1'b0;
    logic [3:0]  code_i = '0;
    logic        use_reg_i = 1'b0;
    logic [63:0] dst_i = '0, src_i = '0, imm_i = '0;
    logic [15:0] off_i = '0;
    logic        out_valid, taken_o, call_o, halt_o, illegal_o;
    logic [63:0] next_pc_o;
    logic [31:0] call_target_o;

    always #4 clk = ~clk;

    branch_next_pc u_branch_next_pc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc_i(pc_i),
        .narrow_i(narrow_i), .code_i(code_i), .use_reg_i(use_reg_i),
        .dst_i(dst_i), .src_i(src_i), .imm_i(imm_i), .off_i(off_i),
        .out_valid(out_valid), .taken_o(taken_o), .next_pc_o(next_pc_o),
        .call_o(call_o), .call_target_o(call_target_o), .halt_o(halt_o),
        .illegal_o(illegal_o)
    );

    typedef struct {
        logic        taken, call, halt, illegal;
        logic [63:0] npc;
        logic [31:0] tgt;
        string       tag;
    } exp_t;

    exp_t expq[$];
    int   checks = 0;
    int   errors = 0;
    logic mon_en = 1'b0;
    logic done = 1'b0;
    logic [63:0] cur_pc = 64'h1000;

    function automatic logic cmp(input logic [3:0] c, input logic [63:0] ua, ub,
                                 input logic signed [63:0] sa, sb);
        case (c)
            4'h1: return ua == ub;
            4'h5: return ua != ub;
            4'h4: return (ua & ub) != 0;
            4'h2: return ua >  ub;
            4'h3: return ua >= ub;
            4'hA: return ua <  ub;
            4'hB: return ua <= ub;
            4'h6: return sa >  sb;
            4'h7: return sa >= sb;
            4'hC: return sa <  sb;
            4'hD: return sa <= sb;
            default: return 1'b0;
        endcase
    endfunction

    function automatic exp_t model(input logic nar, input logic [3:0] c, input logic rs,
                                   input logic [63:0] pc, dst, src, imm,
                                   input logic [15:0] off, input string tag);
        exp_t e;
        logic [63:0] b = rs ? src : imm;
        logic [63:0] ua, ub;
        logic signed [63:0] sa, sb;
        logic signed [63:0] soff = $signed({{48{off[15]}}, off});
        e.taken = 0; e.call = 0; e.halt = 0; e.illegal = 0; e.tgt = '0;
        e.tag = tag;
        e.npc = pc + 64'd8;
        if (nar) begin
            ua = {32'd0, dst[31:0]}; ub = {32'd0, b[31:0]};
            sa = $signed({{32{dst[31]}}, dst[31:0]});
            sb = $signed({{32{b[31]}}, b[31:0]});
        end else begin
            ua = dst; ub = b; sa = $signed(dst); sb = $signed(b);
        end
        if (c >= 4'hE || (nar && (c == 4'h0 || c == 4'h8 || c == 4'h9))) begin
            e.illegal = 1; e.npc = pc;
        end else if (c == 4'h8) begin
            e.call = 1; e.tgt = imm[31:0];
        end else if (c == 4'h9) begin
            e.halt = 1; e.npc = pc;
        end else if (c == 4'h0 || cmp(c, ua, ub, sa, sb)) begin
            e.taken = 1;
            e.npc = pc + 64'((soff + 64'sd1) * 64'sd8);
        end
        return e;
    endfunction

    task automatic send(input logic nar, input logic [3:0] c, input logic rs,
                        input logic [63:0] dst, src, imm, input logic [15:0] off,
                        input string tag);
        @(negedge clk);
        in_valid = 1; narrow_i = nar; code_i = c; use_reg_i = rs;
        dst_i = dst; src_i = src; imm_i = imm; off_i = off; pc_i = cur_pc;
        expq.push_back(model(nar, c, rs, cur_pc, dst, src, imm, off, tag));
        cur_pc = cur_pc + 64'h40;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 0;
        dst_i = '1; imm_i = '1; code_i = 4'h8;
    endtask

    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            if (out_valid) begin
                exp_t e;
                checks++;
                if (expq.size() == 0) begin
                    errors++;
                    $display("FAIL R2: result with nothing expected (actual out_valid=1, expected 0)");
                end else begin
                    e = expq.pop_front();
                    if (taken_o !== e.taken || call_o !== e.call || halt_o !== e.halt ||
                        illegal_o !== e.illegal || next_pc_o !== e.npc || call_target_o !== e.tgt) begin
                        errors++;
                        $display("FAIL %s: actual t%0b c%0b h%0b i%0b pc=%h tgt=%h expected t%0b c%0b h%0b i%0b pc=%h tgt=%h",
                                 e.tag, taken_o, call_o, halt_o, illegal_o, next_pc_o, call_target_o,
                                 e.taken, e.call, e.halt, e.illegal, e.npc, e.tgt);
                    end
                end
            end else begin
                checks++;
                if (taken_o || call_o || halt_o || illegal_o || call_target_o != 0) begin
                    errors++;
                    $display("FAIL R2: idle flags actual %b%b%b%b tgt=%h expected 0000 tgt=0",
                             taken_o, call_o, halt_o, illegal_o, call_target_o);
                end
            end
        end
    end

    task automatic reset_check(input string tag);
        checks++;
        if (out_valid || taken_o || call_o || halt_o || illegal_o ||
            next_pc_o != 0 || call_target_o != 0) begin
            errors++;
            $display("FAIL %s: reset outputs actual v%0b pc=%h expected all zero", tag, out_valid, next_pc_o);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        in_valid = 1'b1; code_i = 4'h0;
        repeat (3) @(negedge clk);
        reset_check("R1");
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reset_check("R1");
        mon_en = 1'b1;

        // R3 always-taken, forward/backward/self offsets
        send(0, 4'h0, 0, 0, 0, 0, 16'd5, "R3");
        send(0, 4'h0, 0, 0, 0, 0, 16'hFFFF, "R3");
        send(0, 4'h0, 0, 0, 0, 0, 16'hFFFD, "R3");
        // R5 equality / bit test
        send(0, 4'h1, 0, 64'd7, 0, 64'd7, 16'd2, "R5");
        send(0, 4'h1, 0, 64'd7, 0, 64'd8, 16'd2, "R4");
        send(0, 4'h5, 0, 64'd7, 0, 64'd8, 16'd3, "R5");
        send(0, 4'h4, 0, 64'h10, 0, 64'h30, 16'd1, "R5");
        send(0, 4'h4, 0, 64'h10, 0, 64'h20, 16'd1, "R5");
        idle();
        idle();
        // R6 / R7 all-ones vs one
        for (int c = 2; c <= 13; c++) begin
            if (c == 4 || c == 5 || c == 8 || c == 9) continue;
            send(0, 4'(c), 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 64'd1, 16'd4,
                 (c == 2 || c == 3 || c == 10 || c == 11) ? "R6" : "R7");
            send(0, 4'(c), 0, 64'd9, 0, 64'd9, 16'd4,
                 (c == 2 || c == 3 || c == 10 || c == 11) ? "R6" : "R7");
        end
        // R8 narrow: upper halves differ
        send(1, 4'h1, 0, 64'h1_0000_0005, 0, 64'd5, 16'd6, "R8");
        send(0, 4'h1, 0, 64'h1_0000_0005, 0, 64'd5, 16'd6, "R8");
        send(1, 4'hC, 0, 64'h0000_0000_8000_0000, 0, 64'd1, 16'd6, "R8");
        send(0, 4'hC, 0, 64'h0000_0000_8000_0000, 0, 64'd1, 16'd6, "R8");
        send(1, 4'h2, 0, 64'hFFFF_FFFF_0000_0001, 0, 64'h0000_0000_0000_0002, 16'd6, "R8");
        // R9 operand select
        send(0, 4'h1, 1, 64'd42, 64'd42, 64'd1, 16'd2, "R9");
        send(0, 4'h1, 0, 64'd42, 64'd42, 64'd1, 16'd2, "R9");
        // R10 call, R11 exit
        send(0, 4'h8, 0, 0, 0, 64'hFFFF_FFFF_8765_4321, 16'd9, "R10");
        send(0, 4'h9, 0, 0, 0, 0, 16'd9, "R11");
        idle();
        // R12 illegal encodings
        send(0, 4'hE, 0, 0, 0, 0, 16'd1, "R12");
        send(1, 4'hF, 0, 0, 0, 0, 16'd1, "R12");
        send(1, 4'h0, 0, 0, 0, 0, 16'd1, "R12");
        send(1, 4'h8, 0, 0, 0, 64'h55, 16'd1, "R12");
        send(1, 4'h9, 0, 0, 0, 0, 16'd1, "R12");
        // R13 mixed back-to-back
        send(0, 4'h6, 1, 64'd3, 64'hFFFF_FFFF_FFFF_FFFE, 0, 16'h8000, "R13");
        idle();
        repeat (3) @(negedge clk);
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R2: results missing actual=%0d expected 0", expq.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule